// File: doc/BRIEF.md
# DDS Tuning Word Loader and Phase Core

This block takes tuning data for a direct digital synthesizer and turns it into a running output phase. Software or a host controller writes a 40-bit word, made of a 32-bit frequency increment and an 8-bit control byte. The word can be written as five bytes on an 8-bit port or as forty bits on a single serial line. Each word-load clock edge adds one byte or one bit to a holding register. A separate update strobe copies the whole holding register into the active frequency and control registers at once. Because of this, a half-written word never reaches the accumulator.

The loader clock and the update strobe are asynchronous to the system clock. Each passes through a small synchronizer, and only its rising edge acts. On every system clock the phase accumulator adds the active frequency word. The output phase is the top of the accumulator plus a phase offset, which is taken from the control byte and aligned to the most significant end.

Reset stops the output and clears the active registers, but the holding register keeps its contents. The control byte has three fields: bits 7:3 hold the phase offset, bits 2:1 hold the mode key, and bit 0 is the clock-multiplier enable, which is only presented as an output.

Top module: `dds_word_loader`

## Requirements
- R1: In parallel mode, the first byte loaded after a reset or an update goes into the control byte. The next four bytes fill the frequency word, most significant byte first, and all eight data lines are used.
- R2: The parallel byte position wraps after five loads, so a sixth byte overwrites the control byte.
- R3: An update strobe returns the parallel byte position to the control byte, even after a partial load.
- R4: A rising edge of the update strobe copies all 40 held bits into `freq_o` and `ctrl_o`. The active registers change at no other time except reset.
- R5: While `rst_i` is high, `freq_o`, `ctrl_o`, `phase_o`, `mult_en_o` and `serial_mode_o` all go to zero. This means parallel mode, 0 Hz and zero phase.
- R6: Reset leaves the holding register unchanged, so an update after reset delivers the word that was loaded before it.
- R7: An update made in parallel mode with control bits 2:1 equal to 2'b11 switches the block into serial mode. The block stays in serial mode until reset.
- R8: In serial mode, each word-load edge shifts in `data_i[7]`. The frequency word arrives least significant bit first, followed by the eight control bits, least significant bit first. Data bits 6:0 are ignored.
- R9: On every system clock the accumulator adds `freq_o`. `phase_o` is the top PHASE_W accumulator bits plus control bits 7:3 placed at the top of the phase, and it is registered one clock behind the accumulator.
- R10: `mult_en_o` follows bit 0 of the active control byte.
- R11: Each rising edge of the word-load clock or the update strobe acts exactly once, however long the pulse stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Asynchronous word-load clock |
| fqud_i | input | 1 | Asynchronous update strobe |
| data_i | input | 8 | Byte port; bit 7 is also the serial line |
| freq_o | output | 32 | Active frequency word |
| ctrl_o | output | 8 | Active control byte |
| phase_o | output | 14 | Output phase |
| mult_en_o | output | 1 | Clock-multiplier enable |
| serial_mode_o | output | 1 | High when the block loads serially |

## Verification
The assertions assume three things about the inputs:
- `data_i` is steady from the word-load edge until at least three system clocks later, when the synchronized edge captures it.
- `wclk_i` and `fqud_i` each stay high and then low for at least three system clocks.
- Both strobes are low while reset is high.

The bench meets these conditions by changing data and strobes only on falling clock edges. Every strobe is held high for four clocks and then low for four clocks, and the data stays unchanged for the whole pulse. Under these conditions the accumulator-step, byte-position and sticky-mode properties hold from the first cycle after reset.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

  // Control byte field positions (decoded by the phase core).
  localparam int MULT_BIT  = 0;
  localparam int MODE_LSB  = 1;
  localparam int MODE_W    = 2;
  localparam int OFS_LSB   = 3;
  localparam int OFS_W     = 5;

  localparam logic [MODE_W-1:0] SERIAL_KEY = 2'b11;

  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_t;

endpackage

// File: rtl/dds_edge_sync.sv
module dds_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) last_q <= 1'b0;
    else       last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // R11: a detected edge lasts exactly one system clock
  p_one_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);

endmodule

// File: rtl/dds_word_assembler.sv
module dds_word_assembler
  import dds_ldr_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int CTRL_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       load_i,
  input  logic                       clear_i,
  input  load_mode_t                 mode_i,
  input  logic [BYTE_W-1:0]          data_i,
  output logic [FREQ_W+CTRL_W-1:0]   hold_o
);

  localparam int HOLD_W = FREQ_W + CTRL_W;
  localparam int NBYTES = HOLD_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NBYTES-1:0] lane_we;
  logic              par_load;
  logic              ser_load;

  assign par_load = load_i && (mode_i == LOAD_PAR);
  assign ser_load = load_i && (mode_i == LOAD_SER);

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign lane_we[b] = par_load && (cnt_q == CNT_W'(b));
    end
  endgenerate

  // Holding register: no reset, survives a core reset.
  always_ff @(posedge clk_i) begin
    if (ser_load) begin
      hold_q <= {data_i[BYTE_W-1], hold_q[HOLD_W-1:1]};
    end else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (lane_we[b])
          hold_q[HOLD_W-1-BYTE_W*b -: BYTE_W] <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i)
      cnt_q <= '0;
    else if (par_load)
      cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
  end

  assign hold_o = hold_q;

  // R2: byte position never leaves the word
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST_IDX);

  // R3: update returns the position to the control byte
  p_cnt_clear_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    clear_i |=> cnt_q == '0);

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_ldr_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int CTRL_W  = 8,
  parameter int PHASE_W = 14
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      update_i,
  input  logic [FREQ_W+CTRL_W-1:0]  hold_i,
  output logic [FREQ_W-1:0]         freq_o,
  output logic [CTRL_W-1:0]         ctrl_o,
  output logic [PHASE_W-1:0]        phase_o,
  output logic                      mult_en_o,
  output load_mode_t                mode_o
);

  localparam int PAD_W = PHASE_W - OFS_W;

  logic [FREQ_W-1:0]  freq_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [FREQ_W-1:0]  acc_q;
  logic [PHASE_W-1:0] phase_q;
  load_mode_t         mode_q;

  logic [FREQ_W-1:0]  hold_freq;
  logic [CTRL_W-1:0]  hold_ctrl;
  logic [PHASE_W-1:0] ofs_ext;
  logic               key_hit;

  assign hold_freq = hold_i[FREQ_W-1:0];
  assign hold_ctrl = hold_i[FREQ_W+CTRL_W-1:FREQ_W];
  assign key_hit   = hold_ctrl[MODE_LSB +: MODE_W] == SERIAL_KEY;
  assign ofs_ext   = {ctrl_q[OFS_LSB +: OFS_W], {PAD_W{1'b0}}};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      freq_q <= '0;
      ctrl_q <= '0;
      mode_q <= LOAD_PAR;
    end else if (update_i) begin
      freq_q <= hold_freq;
      ctrl_q <= hold_ctrl;
      if (mode_q == LOAD_PAR && key_hit)
        mode_q <= LOAD_SER;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else begin
      acc_q   <= acc_q + freq_q;
      phase_q <= acc_q[FREQ_W-1 -: PHASE_W] + ofs_ext;
    end
  end

  assign freq_o    = freq_q;
  assign ctrl_o    = ctrl_q;
  assign phase_o   = phase_q;
  assign mult_en_o = ctrl_q[MULT_BIT];
  assign mode_o    = mode_q;

  // R4: active words only move on an update
  p_active_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !update_i |=> $stable(freq_q) && $stable(ctrl_q));

  // R9: accumulator advances by the active word each clock
  p_acc_step_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> acc_q == $past(acc_q) + $past(freq_q));

  // R7: serial mode is left only through reset
  p_serial_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_q == LOAD_SER |=> mode_q == LOAD_SER);

endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_ldr_pkg::*;
#(
  parameter int FREQ_W      = 32,
  parameter int CTRL_W      = 8,
  parameter int BYTE_W      = 8,
  parameter int PHASE_W     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wclk_i,
  input  logic               fqud_i,
  input  logic [BYTE_W-1:0]  data_i,
  output logic [FREQ_W-1:0]  freq_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               mult_en_o,
  output logic               serial_mode_o
);

  localparam int HOLD_W = FREQ_W + CTRL_W;

  logic              load_rise;
  logic              upd_rise;
  logic [HOLD_W-1:0] hold;
  load_mode_t        mode;

  dds_edge_sync #(.STAGES(SYNC_STAGES)) i_load_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (wclk_i),
    .rise_o  (load_rise)
  );

  dds_edge_sync #(.STAGES(SYNC_STAGES)) i_upd_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (fqud_i),
    .rise_o  (upd_rise)
  );

  dds_word_assembler #(
    .FREQ_W (FREQ_W),
    .CTRL_W (CTRL_W),
    .BYTE_W (BYTE_W)
  ) i_asm (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load_rise),
    .clear_i (upd_rise),
    .mode_i  (mode),
    .data_i  (data_i),
    .hold_o  (hold)
  );

  dds_phase_core #(
    .FREQ_W  (FREQ_W),
    .CTRL_W  (CTRL_W),
    .PHASE_W (PHASE_W)
  ) i_core (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .update_i  (upd_rise),
    .hold_i    (hold),
    .freq_o    (freq_o),
    .ctrl_o    (ctrl_o),
    .phase_o   (phase_o),
    .mult_en_o (mult_en_o),
    .mode_o    (mode)
  );

  assign serial_mode_o = (mode == LOAD_SER);

endmodule

// File: tb/test_dds_word_loader.sv
module test_dds_word_loader;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  // each entry: {control byte, frequency word}; control bits 2:1 never 2'b11
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h81, 32'h0123_4567},
    {8'h28, 32'hDEAD_BEEF},
    {8'hF9, 32'h8000_0001},
    {8'h12, 32'h00FF_FF00}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        wclk;
  logic        fqud;
  logic [7:0]  data;
  logic [31:0] freq;
  logic [7:0]  ctrl;
  logic [13:0] phase;
  logic        mult_en;
  logic        ser;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_word_loader i_dds_word_loader (
    .clk_i         (clk),
    .rst_i         (rst),
    .wclk_i        (wclk),
    .fqud_i        (fqud),
    .data_i        (data),
    .freq_o        (freq),
    .ctrl_o        (ctrl),
    .phase_o       (phase),
    .mult_en_o     (mult_en),
    .serial_mode_o (ser)
  );

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_wclk(logic [7:0] b);
    @(negedge clk);
    data = b;
    wclk = 1'b1;
    repeat (4) @(negedge clk);
    wclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_update();
    @(negedge clk);
    fqud = 1'b1;
    repeat (4) @(negedge clk);
    fqud = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_par(logic [7:0] c, logic [31:0] f);
    pulse_wclk(c);
    for (int i = 3; i >= 0; i--) pulse_wclk(f[8*i +: 8]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [13:0] p0;
    rst = 1'b1; wclk = 1'b0; fqud = 1'b0; data = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5: reset state
    check("R5 freq", freq, 0);
    check("R5 ctrl", ctrl, 0);
    check("R5 phase", phase, 0);
    check("R5 mult/serial", {mult_en, ser}, 0);

    // R1 R4 R10: vector table walk
    for (int v = 0; v < NVEC; v++) begin
      load_par(VEC[v][39:32], VEC[v][31:0]);
      check("R4 freq unchanged before update", freq, (v == 0) ? 32'h0 : VEC[v-1][31:0]);
      pulse_update();
      check("R1 freq", freq, VEC[v][31:0]);
      check("R1 ctrl", ctrl, VEC[v][39:32]);
      check("R10 mult_en", mult_en, VEC[v][32]);
    end

    // R2: sixth byte overwrites control
    load_par(8'h40, 32'hA1B2_C3D4);
    pulse_wclk(8'h98);
    pulse_update();
    check("R2 ctrl wrapped", ctrl, 8'h98);
    check("R2 freq", freq, 32'hA1B2_C3D4);

    // R3: partial load then update resets byte position
    pulse_wclk(8'h20);
    pulse_wclk(8'h77);
    pulse_update();
    check("R3 partial ctrl", ctrl, 8'h20);
    check("R3 partial freq", freq, 32'h77B2_C3D4);
    pulse_wclk(8'h48);
    pulse_update();
    check("R3 byte after update goes to ctrl", ctrl, 8'h48);
    check("R3 freq untouched", freq, 32'h77B2_C3D4);

    // R6 R9: holding register survives reset; offset placement
    load_par(8'hA8, 32'h0000_0000);
    do_reset();
    check("R5 ctrl after reset", ctrl, 0);
    check("R5 phase after reset", phase, 0);
    pulse_update();
    check("R6 ctrl from held word", ctrl, 8'hA8);
    check("R9 offset in phase", phase, 14'h2A00);

    // R9: accumulator step (increment 4 in the top 14 bits)
    load_par(8'h00, 32'h0010_0000);
    pulse_update();
    p0 = phase;
    @(negedge clk);
    check("R9 phase step", 14'(phase - p0), 14'd4);
    p0 = phase;
    @(negedge clk);
    check("R9 phase step again", 14'(phase - p0), 14'd4);

    // R7: key pattern enters serial mode
    load_par(8'h06, 32'h0000_0000);
    pulse_update();
    check("R7 serial entered", ser, 1'b1);

    // R8 R11: serial shift on data bit 7, junk on bits 6:0
    begin
      logic [39:0] w;
      w = {8'h51, 32'hC0FF_EE11};
      for (int i = 0; i < 40; i++) pulse_wclk({w[i], 7'h55});
      pulse_update();
      check("R8 serial freq", freq, w[31:0]);
      check("R8 serial ctrl", ctrl, w[39:32]);
      check("R10 mult_en serial", mult_en, 1'b1);
      check("R7 serial sticky", ser, 1'b1);
    end

    // R5: reset returns to parallel and drops the multiplier enable
    do_reset();
    check("R5 serial cleared", ser, 1'b0);
    check("R5 mult cleared", mult_en, 1'b0);
    check("R5 freq cleared", freq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule